// File: doc/BRIEF.md
# Serial-Bus Control Register Slave

This block is a two-wire serial slave (I2C, standard and fast mode up to 400 kHz) that exposes a bank of four 8-bit control registers to an external host. A fast system clock (at least 10 MHz) oversamples the SCL and SDA lines through a synchroniser. The block recognises START and STOP conditions, compares the incoming 7-bit device address with its own, acknowledges bytes, and runs write transfers, current-address reads and random reads. The block never drives SDA high. It only asserts a pull-low enable that an open-drain pad turns into a low level.

The device address is the fixed 6-bit prefix `001001` followed by the level of a strap pin. The first byte of a write sets a register pointer. Each later byte goes to the register at the pointer, and the pointer then advances. Reads return bytes from the pointer and advance it in the same way. The pointer steps from register 3 back to register 0. The register contents drive named control fields to the rest of the chip. Bits without storage read as zero and ignore writes.

Top module: `ctlreg_i2c_slave`

## Requirements
- R1: After reset the registers hold 0 = 00h, 1 = 00h, 2 = 06h and 3 = 44h. The outputs are then pwr_en_o = 0, adc_fmt_o = 0, adc_ratio_o = 3 and dac_cfg_o = 44h.
- R2: The block acknowledges a first byte (pulls SDA low in the ninth clock) only when its upper 7 bits equal `001001` followed by addr_sel_i. The lowest bit selects the direction, with 1 meaning read. Any other address gets no acknowledge, and the block ignores the rest of that transfer.
- R3: In a write, the byte after the address loads the pointer from its low 5 bits and ignores its top 3 bits. Each following data byte is acknowledged and stored in the register at the pointer, and the pointer then advances.
- R4: The pointer advances from register 3 back to register 0.
- R5: Only these bits are writable: register 0 bits 1:0, register 2 bits 4, 2 and 1, and register 3 bits 6:0. Register 1 is fully read-only. All other bits read as 0. Outputs: pwr_en_o = reg0[1:0], adc_fmt_o = reg2[4], adc_ratio_o = reg2[2:1], dac_cfg_o = reg3[6:0].
- R6: A random read (address write, pointer byte, repeated START, address read) returns bytes starting at the new pointer. Each byte read advances the pointer.
- R7: A current-address read starts at the pointer left by the previous transfer, which is one past the last register written or read.
- R8: When the host does not acknowledge a read byte, the block stops driving SDA and waits for the next START or STOP. The pull-low enable is asserted only in acknowledge slots and read data bits.
- R9: A START or STOP that arrives partway through a byte abandons the transfer without writing any register. A new START restarts address reception.
- R10: The pull-low enable changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus (at least 10 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | When 1, the pad pulls SDA low |
| addr_sel_i | input | 1 | Strap pin giving the lowest device address bit |
| pwr_en_o | output | 2 | Power enables, register 0 bits 1:0 |
| adc_fmt_o | output | 1 | Converter-side format select, register 2 bit 4 |
| adc_ratio_o | output | 2 | Converter-side clock ratio, register 2 bits 2:1 |
| dac_cfg_o | output | 7 | Playback configuration, register 3 bits 6:0 |

## Verification
The assertions assume a well-formed host. SDA changes only while SCL is low, except for START and STOP edges. Every SCL high and low phase lasts well beyond the synchroniser delay of three system clocks. The host never forms a START or STOP while the slave holds SDA low. The bench host drives the bus through an open-drain model. It holds each quarter of an SCL period for eight system clocks and moves SDA only in the middle of SCL low. Abandoned transfers are also cut short on SCL low, before the START or STOP edge is made.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam int NREG  = 4;
  localparam int PTR_W = 5;
  localparam int DW    = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACK_A, S_RX, S_ACK_RX, S_LOAD, S_TX, S_ACK_TX
  } eng_state_t;

  function automatic logic [DW-1:0] reg_reset_val(input int idx);
    case (idx)
      2:       return 8'h06;
      3:       return 8'h44;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_wr_mask(input int idx);
    case (idx)
      0:       return 8'h03;
      2:       return 8'h16;
      3:       return 8'h7F;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cr_regbank.sv
module i2cr_regbank
  import i2cr_pkg::*;
#(
  parameter int N  = NREG,
  parameter int PW = PTR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] ptr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [N*DW-1:0] regs_flat
);
  logic [DW-1:0] r [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r[g] <= reg_reset_val(g);
      else if (wr_en && ptr == PW'(g))
        r[g] <= wr_data & reg_wr_mask(g);
    end
    assign regs_flat[g*DW +: DW] = r[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++)
      if (ptr == PW'(i)) rd_data = r[i];
  end

  // R3
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(regs_flat));
endmodule

// File: rtl/i2cr_engine.sv
module i2cr_engine
  import i2cr_pkg::*;
#(
  parameter logic [5:0] DEV_PREFIX = 6'b001001,
  parameter int         PW         = PTR_W,
  parameter int         LAST_REG   = NREG - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          addr_sel,
  input  logic [DW-1:0] rd_data,
  output logic          sda_pull,
  output logic          wr_en,
  output logic [DW-1:0] sh,
  output logic [PW-1:0] ptr
);
  eng_state_t st;
  logic [3:0] cnt;
  logic       is_read, got_ptr, inc_pend, nack;
  logic [PW-1:0] ptr_nxt;

  assign ptr_nxt = (ptr == PW'(LAST_REG)) ? '0 : ptr + 1'b1;
  wire addr_hit = (sh[7:1] == {DEV_PREFIX, addr_sel});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; sda_pull <= 1'b0; ptr <= '0;
      is_read <= 1'b0; got_ptr <= 1'b0; inc_pend <= 1'b0; nack <= 1'b0;
      wr_en <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st <= S_ADDR; cnt <= '0; sda_pull <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE; sda_pull <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_RX: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (addr_hit) begin
                  st <= S_ACK_A; sda_pull <= 1'b1; is_read <= sh[0];
                end else st <= S_IDLE;
              end else begin
                st <= S_ACK_RX; sda_pull <= 1'b1;
                if (!got_ptr) begin
                  ptr <= sh[PW-1:0]; got_ptr <= 1'b1; inc_pend <= 1'b0;
                end else begin
                  wr_en <= 1'b1; inc_pend <= 1'b1;
                end
              end
            end
          end
          S_ACK_A: if (scl_fall) begin
            sda_pull <= 1'b0;
            got_ptr  <= 1'b0;
            st       <= is_read ? S_LOAD : S_RX;
          end
          S_ACK_RX: if (scl_fall) begin
            sda_pull <= 1'b0;
            st       <= S_RX;
            if (inc_pend) ptr <= ptr_nxt;
          end
          S_LOAD: begin
            sh <= rd_data; sda_pull <= ~rd_data[7]; cnt <= '0; st <= S_TX;
          end
          S_TX: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_pull <= 1'b0; st <= S_ACK_TX;
              end else begin
                sh <= {sh[6:0], 1'b0}; sda_pull <= ~sh[6];
              end
            end
          end
          S_ACK_TX: begin
            if (scl_rise) nack <= sda_s;
            else if (scl_fall) begin
              ptr <= ptr_nxt;
              st  <= nack ? S_IDLE : S_LOAD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  pull_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull));
  // R8
  pull_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (st inside {S_ACK_A, S_ACK_RX, S_TX}));
  // R9
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_ADDR && cnt == 4'd0));
  // R2
  ack_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK_A) |-> sda_pull);
endmodule

// File: rtl/ctlreg_i2c_slave.sv
module ctlreg_i2c_slave
  import i2cr_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_PREFIX  = 6'b001001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic       addr_sel_i,
  output logic [1:0] pwr_en_o,
  output logic       adc_fmt_o,
  output logic [1:0] adc_ratio_o,
  output logic [6:0] dac_cfg_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [DW-1:0] sh, rd_data;
  logic [PTR_W-1:0] ptr;
  logic [NREG*DW-1:0] regs_flat;

  i2cr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cr_engine #(.DEV_PREFIX(DEV_PREFIX), .PW(PTR_W), .LAST_REG(NREG-1)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .addr_sel(addr_sel_i), .rd_data(rd_data),
    .sda_pull(sda_pull_o), .wr_en(wr_en), .sh(sh), .ptr(ptr)
  );

  i2cr_regbank #(.N(NREG), .PW(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr), .wr_data(sh),
    .rd_data(rd_data), .regs_flat(regs_flat)
  );

  assign pwr_en_o    = regs_flat[1:0];
  assign adc_fmt_o   = regs_flat[2*DW+4];
  assign adc_ratio_o = regs_flat[2*DW+2 : 2*DW+1];
  assign dac_cfg_o   = regs_flat[3*DW+6 : 3*DW];

  logic unused_bits;
  assign unused_bits = ^{regs_flat[DW*2-1:2], regs_flat[2*DW+7:2*DW+5],
                         regs_flat[2*DW+3], regs_flat[2*DW], regs_flat[4*DW-1]};
endmodule

// File: tb/sim_ctlreg_i2c_slave.sv
module sim_ctlreg_i2c_slave;
  localparam int Q = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sda_pull;
  logic [1:0] pwr_en, adc_ratio;
  logic adc_fmt;
  logic [6:0] dac_cfg;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  wire sda_line = sda_m & ~sda_pull;

  always #4 clk = ~clk;

  ctlreg_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .addr_sel_i(addr_sel), .pwr_en_o(pwr_en),
    .adc_fmt_o(adc_fmt), .adc_ratio_o(adc_ratio), .dac_cfg_o(dac_cfg)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; waitq(2*Q); scl = 1'b0; waitq(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; waitq(Q); scl = 1'b1; waitq(Q); sda_m = 1'b0; waitq(Q);
    scl = 1'b0; waitq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq(Q); scl = 1'b1; waitq(Q); sda_m = 1'b1; waitq(4*Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; waitq(Q); scl = 1'b1; waitq(2*Q); scl = 1'b0; waitq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; waitq(Q); scl = 1'b1; waitq(Q); b = sda_line;
    waitq(Q); scl = 1'b0; waitq(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(~host_ack);
  endtask

  task automatic t_reset();
    check("R1 pwr_en", pwr_en, 0);
    check("R1 adc_fmt", adc_fmt, 0);
    check("R1 adc_ratio", adc_ratio, 3);
    check("R1 dac_cfg", dac_cfg, 'h44);
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start(); send_byte(8'h26, a); bus_stop();
    check("R2 foreign address nack", a, 0);
    check("R2 no effect", dac_cfg, 'h44);
  endtask

  task automatic t_burst_write_read();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'h24, a);
    check("R2 own address ack", a, 1);
    send_byte(8'h00, a);
    for (int i = 0; i < 4; i++) begin
      send_byte(8'hFF, a);
      check("R3 data ack", a, 1);
    end
    bus_stop();
    check("R5 pwr_en", pwr_en, 3);
    check("R5 adc_fmt", adc_fmt, 1);
    check("R5 adc_ratio", adc_ratio, 3);
    check("R5 dac_cfg", dac_cfg, 'h7F);
    bus_start(); send_byte(8'h24, a); send_byte(8'h00, a);
    bus_rstart(); send_byte(8'h25, a);
    check("R6 read address ack", a, 1);
    recv_byte(1, d); check("R5 reg0 readback", d, 'h03);
    recv_byte(1, d); check("R5 reg1 read-only", d, 'h00);
    recv_byte(1, d); check("R5 reg2 readback", d, 'h16);
    recv_byte(0, d); check("R6 reg3 readback", d, 'h7F);
    check("R8 released after nack", sda_pull, 0);
    bus_stop();
  endtask

  task automatic t_wrap_write();
    logic a;
    bus_start(); send_byte(8'h24, a); send_byte(8'hE3, a);
    send_byte(8'h12, a); send_byte(8'h01, a); bus_stop();
    check("R3 top pointer bits ignored", dac_cfg, 'h12);
    check("R4 wrap to reg0", pwr_en, 1);
  endtask

  task automatic t_current_read();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'h24, a); send_byte(8'h02, a);
    bus_rstart(); send_byte(8'h25, a);
    recv_byte(0, d); check("R6 random read reg2", d, 'h16);
    bus_stop();
    bus_start(); send_byte(8'h25, a);
    recv_byte(1, d); check("R7 current read reg3", d, 'h12);
    recv_byte(0, d); check("R4 read wrap reg0", d, 'h01);
    bus_stop();
  endtask

  task automatic t_abandon();
    logic a;
    bus_start(); send_byte(8'h24, a); send_byte(8'h00, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    check("R9 stop mid-byte no write", pwr_en, 1);
    bus_start(); send_byte(8'h24, a); send_byte(8'h03, a);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    bus_rstart(); send_byte(8'h24, a);
    check("R9 restart accepted", a, 1);
    send_byte(8'h03, a); send_byte(8'h55, a); bus_stop();
    check("R9 write after restart", dac_cfg, 'h55);
    check("R9 other reg untouched", pwr_en, 1);
  endtask

  task automatic t_addr_sel();
    logic a;
    addr_sel = 1'b1; waitq(4);
    bus_start(); send_byte(8'h24, a); bus_stop();
    check("R2 old address nack", a, 0);
    bus_start(); send_byte(8'h26, a);
    check("R2 strap address ack", a, 1);
    send_byte(8'h00, a); send_byte(8'h02, a); bus_stop();
    check("R2 strap write", pwr_en, 2);
  endtask

  initial begin
    waitq(5); rst_n = 1'b1; waitq(5);
    t_reset();
    t_wrong_addr();
    t_burst_write_read();
    t_wrap_write();
    t_current_read();
    t_abandon();
    t_addr_sel();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule